// File: doc/BRIEF.md
# Bus Cycle Break Channel

This block is one channel of a debug break unit. It observes every bus cycle issued by either the CPU or a DMA master. Each cycle is compared against a programmed address, where a per-bit mask can exclude any bit from the comparison. The cycle must also pass a direction filter and a bus-master filter. A qualifying cycle, called a hit, sets a sticky flag for the master that caused it and may raise a one-cycle break request toward the interrupt logic.

Two options change when the break request is raised. An occurrence counter can hold the break back until the condition has been hit a programmed number of times. For instruction-fetch hits, the break can be placed before execution, which raises it at once. It can also be placed after execution, which holds it until the core signals that the fetched instruction has completed.

Software reaches all state through a four-entry register port. Writes take effect at the clock edge and reads are combinational. The entries are: index 0 match address, index 1 address mask, index 2 control, index 3 occurrence count.

Top module: `brk_channel`

## Requirements
- R1: After reset, all four registers read 0, both flags are 0 and `brk_req_o` is 0. A control value of 0 selects no master, so nothing can hit.
- R2: An address hit requires `bus_addr_i` to equal the match address in every bit whose mask bit is 0. Bits with mask 1 are ignored.
- R3: Control bits [1:0] select the masters. Bit 0 enables CPU cycles (`bus_dma_i`=0) and bit 1 enables DMA cycles (`bus_dma_i`=1).
- R4: Control bits [3:2] select the direction. Bit 2 enables reads (`bus_write_i`=0) and bit 3 enables writes.
- R5: Control bit 8 is the CPU flag. Any hit by a CPU cycle sets it. Writing control with bit 8 = 0 clears it, and writing 1 leaves it unchanged. A hit in the same cycle as a clearing write leaves it set.
- R6: Control bit 9 is the DMA flag. It follows the same rules as the CPU flag, but is set by DMA hits.
- R7: With control bit 5 (count enable) at 0, every hit whose break is not deferred pulses `brk_req_o` high in the cycle after the hit.
- R8: With count enable at 1, each hit lowers a nonzero count by one. The break fires only on a hit that finds the count at 1, after which the count reads 0. A count of 0 neither decrements nor breaks.
- R9: With control bit 4 at 0 (before execution), a fetch hit breaks in the next cycle, the same as any other hit.
- R10: With control bit 4 at 1, a breaking fetch hit (`bus_fetch_i`=1) is held pending. `brk_req_o` pulses in the cycle after `insn_done_i` is seen while a break is pending. `insn_done_i` has no effect when no break is pending.
- R11: Control bits 7:6 and 31:10 always read 0, and writes to them have no effect.
- R12: A count write in the same cycle as a hit loads the written value. The break decision for that hit still uses the count held before the write.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Bus clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| reg_we_i | input | 1 | Register write strobe |
| reg_addr_i | input | 2 | Register index |
| reg_wdata_i | input | DW | Register write data |
| reg_rdata_o | output | DW | Register read data, combinational |
| bus_valid_i | input | 1 | A bus cycle is present |
| bus_addr_i | input | AW | Bus cycle address |
| bus_write_i | input | 1 | 1 = write cycle, 0 = read |
| bus_dma_i | input | 1 | 1 = DMA master, 0 = CPU |
| bus_fetch_i | input | 1 | Cycle is an instruction fetch |
| insn_done_i | input | 1 | Instruction-completion strobe |
| brk_req_o | output | 1 | Break request pulse |

## Verification
Several properties are checked on every cycle:
- Each flag stays set unless a clearing write occurs, and any hit by its master sets it.
- A count that finds 1 on a non-deferred hit always produces a break.
- A count of 0 is stable without a reload.
- No break appears without either a hit or a completed pending fetch.
- Reserved control bits read zero.

Only the bench scenarios can show the address-mask, master and direction filtering. The same holds for the exact cycle of a deferred break, write-versus-hit collisions on the count, and the full value of each register across long random sequences.

// File: rtl/brk_pkg.sv
package brk_pkg;
  typedef enum logic [1:0] {
    RA_ADDR = 2'd0,
    RA_MASK = 2'd1,
    RA_CTRL = 2'd2,
    RA_CNT  = 2'd3
  } reg_sel_e;

  localparam int CB_AFTER = 4;
  localparam int CB_CNTEN = 5;
  localparam int CB_CPU_F = 8;
  localparam int CB_DMA_F = 9;
  localparam int CFG_W    = 6;

  typedef struct packed {
    logic       cnt_en;
    logic       after;
    logic [1:0] dir;   // [0] read, [1] write
    logic [1:0] mst;   // [0] cpu, [1] dma
  } brk_cfg_t;
endpackage

// File: rtl/brk_match.sv
module brk_match #(
  parameter int AW = 32
) (
  input  logic [AW-1:0]     cmp_addr_i,
  input  logic [AW-1:0]     mask_i,
  input  brk_pkg::brk_cfg_t cfg_i,
  input  logic              valid_i,
  input  logic [AW-1:0]     addr_i,
  input  logic              write_i,
  input  logic              dma_i,
  output logic              hit_o
);
  logic [AW-1:0] bit_ok;

  for (genvar i = 0; i < AW; i++) begin : g_bit
    assign bit_ok[i] = mask_i[i] | (addr_i[i] ~^ cmp_addr_i[i]);
  end

  logic mst_ok, dir_ok;
  assign mst_ok = dma_i   ? cfg_i.mst[1] : cfg_i.mst[0];
  assign dir_ok = write_i ? cfg_i.dir[1] : cfg_i.dir[0];
  assign hit_o  = valid_i & (&bit_ok) & mst_ok & dir_ok;
endmodule

// File: rtl/brk_regs.sv
module brk_regs #(
  parameter int AW = 32,
  parameter int DW = 32,
  parameter int CW = 16
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              we_i,
  input  logic [1:0]        addr_i,
  input  logic [DW-1:0]     wdata_i,
  output logic [DW-1:0]     rdata_o,
  input  logic              hit_i,
  input  logic              dma_i,
  input  logic [CW-1:0]     cnt_i,
  output logic [AW-1:0]     cmp_addr_o,
  output logic [AW-1:0]     mask_o,
  output brk_pkg::brk_cfg_t cfg_o,
  output logic              cnt_we_o,
  output logic              cpu_f_o,
  output logic              dma_f_o
);
  import brk_pkg::*;

  reg_sel_e sel;
  logic     ctrl_we, cpu_clr, dma_clr;

  assign sel      = reg_sel_e'(addr_i);
  assign ctrl_we  = we_i && (sel == RA_CTRL);
  assign cnt_we_o = we_i && (sel == RA_CNT);
  assign cpu_clr  = ctrl_we && !wdata_i[CB_CPU_F];
  assign dma_clr  = ctrl_we && !wdata_i[CB_DMA_F];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cmp_addr_o <= '0;
      mask_o     <= '0;
      cfg_o      <= '0;
    end else if (we_i) begin
      case (sel)
        RA_ADDR: cmp_addr_o <= wdata_i[AW-1:0];
        RA_MASK: mask_o     <= wdata_i[AW-1:0];
        RA_CTRL: cfg_o      <= brk_cfg_t'(wdata_i[CFG_W-1:0]);
        default: ;
      endcase
    end
  end

  // hardware set wins over a clearing write
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cpu_f_o <= 1'b0;
      dma_f_o <= 1'b0;
    end else begin
      cpu_f_o <= (hit_i & ~dma_i) | (cpu_f_o & ~cpu_clr);
      dma_f_o <= (hit_i &  dma_i) | (dma_f_o & ~dma_clr);
    end
  end

  always_comb begin
    rdata_o = '0;
    case (sel)
      RA_ADDR: rdata_o = DW'(cmp_addr_o);
      RA_MASK: rdata_o = DW'(mask_o);
      RA_CTRL: begin
        rdata_o[CFG_W-1:0] = cfg_o;
        rdata_o[CB_CPU_F]  = cpu_f_o;
        rdata_o[CB_DMA_F]  = dma_f_o;
      end
      RA_CNT:  rdata_o = DW'(cnt_i);
      default: ;
    endcase
  end

  logic unused_wdata;
  assign unused_wdata = ^{wdata_i[DW-1:CB_DMA_F+1], wdata_i[CB_CPU_F-1:CFG_W]};
endmodule

// File: rtl/brk_count.sv
module brk_count #(
  parameter int CW = 16
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          hit_i,
  input  logic          fetch_i,
  input  logic          done_i,
  input  logic          cnt_en_i,
  input  logic          after_i,
  input  logic          cnt_we_i,
  input  logic [CW-1:0] cnt_wdata_i,
  output logic [CW-1:0] cnt_o,
  output logic          pending_o,
  output logic          brk_req_o
);
  localparam logic [CW-1:0] ONE = CW'(1);

  logic fire, defer, cnt_zero;

  assign cnt_zero = (cnt_o == '0);
  assign fire     = cnt_en_i ? (hit_i && cnt_o == ONE) : hit_i;
  assign defer    = fire && fetch_i && after_i;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_o <= '0;
    end else if (cnt_we_i) begin
      cnt_o <= cnt_wdata_i;
    end else if (cnt_en_i && hit_i && !cnt_zero) begin
      cnt_o <= cnt_o - ONE;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      pending_o <= 1'b0;
      brk_req_o <= 1'b0;
    end else begin
      brk_req_o <= (fire && !defer) || (pending_o && done_i);
      if (defer)       pending_o <= 1'b1;
      else if (done_i) pending_o <= 1'b0;
    end
  end
endmodule

// File: rtl/brk_channel.sv
module brk_channel #(
  parameter int AW = 32,
  parameter int DW = 32,
  parameter int CW = 16
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          reg_we_i,
  input  logic [1:0]    reg_addr_i,
  input  logic [DW-1:0] reg_wdata_i,
  output logic [DW-1:0] reg_rdata_o,
  input  logic          bus_valid_i,
  input  logic [AW-1:0] bus_addr_i,
  input  logic          bus_write_i,
  input  logic          bus_dma_i,
  input  logic          bus_fetch_i,
  input  logic          insn_done_i,
  output logic          brk_req_o
);
  import brk_pkg::*;

  logic [AW-1:0] cmp_addr, mask;
  brk_cfg_t      cfg;
  logic          hit, cnt_we, pending, cpu_f, dma_f;
  logic [CW-1:0] cnt;

  brk_match #(.AW(AW)) u_match (
    .cmp_addr_i(cmp_addr), .mask_i(mask), .cfg_i(cfg),
    .valid_i(bus_valid_i), .addr_i(bus_addr_i),
    .write_i(bus_write_i), .dma_i(bus_dma_i), .hit_o(hit)
  );

  brk_regs #(.AW(AW), .DW(DW), .CW(CW)) u_regs (
    .clk_i(clk_i), .rst_ni(rst_ni),
    .we_i(reg_we_i), .addr_i(reg_addr_i), .wdata_i(reg_wdata_i),
    .rdata_o(reg_rdata_o), .hit_i(hit), .dma_i(bus_dma_i), .cnt_i(cnt),
    .cmp_addr_o(cmp_addr), .mask_o(mask), .cfg_o(cfg),
    .cnt_we_o(cnt_we), .cpu_f_o(cpu_f), .dma_f_o(dma_f)
  );

  brk_count #(.CW(CW)) u_count (
    .clk_i(clk_i), .rst_ni(rst_ni),
    .hit_i(hit), .fetch_i(bus_fetch_i), .done_i(insn_done_i),
    .cnt_en_i(cfg.cnt_en), .after_i(cfg.after),
    .cnt_we_i(cnt_we), .cnt_wdata_i(reg_wdata_i[CW-1:0]),
    .cnt_o(cnt), .pending_o(pending), .brk_req_o(brk_req_o)
  );
endmodule

// File: rtl/brk_channel_chk.sv
module brk_channel_chk #(
  parameter int DW = 32,
  parameter int CW = 16
) (
  input logic          clk_i,
  input logic          rst_ni,
  input logic          reg_we_i,
  input logic [1:0]    reg_addr_i,
  input logic [DW-1:0] reg_wdata_i,
  input logic [DW-1:0] reg_rdata_o,
  input logic          bus_dma_i,
  input logic          bus_fetch_i,
  input logic          insn_done_i,
  input logic          brk_req_o,
  input logic          hit,
  input logic          pending,
  input logic [CW-1:0] cnt,
  input logic          cpu_f,
  input logic          dma_f,
  input logic          cnt_en,
  input logic          after
);
  logic ctrl_wr, cnt_wr;
  assign ctrl_wr = reg_we_i && reg_addr_i == 2'd2;
  assign cnt_wr  = reg_we_i && reg_addr_i == 2'd3;

  // R5
  cpu_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cpu_f && !(ctrl_wr && !reg_wdata_i[8]) |=> cpu_f);
  // R5
  cpu_set_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    hit && !bus_dma_i |=> cpu_f);
  // R6
  dma_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    dma_f && !(ctrl_wr && !reg_wdata_i[9]) |=> dma_f);
  // R6
  dma_set_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    hit && bus_dma_i |=> dma_f);
  // R8
  cnt_fire_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cnt_en && hit && cnt == CW'(1) && !(bus_fetch_i && after) |=> brk_req_o);
  // R8
  cnt_zero_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cnt == '0 && !cnt_wr |=> cnt == '0);
  // R10
  no_spurious_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !hit && !(pending && insn_done_i) |=> !brk_req_o);
  // R10
  defer_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    hit && !cnt_en && after && bus_fetch_i && !(pending && insn_done_i)
    |=> !brk_req_o && pending);
  // R11
  rsvd_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    reg_addr_i == 2'd2 |-> reg_rdata_o[DW-1:10] == '0 && reg_rdata_o[7:6] == 2'b00);
endmodule

bind brk_channel brk_channel_chk #(.DW(DW), .CW(CW)) u_chk (
  .clk_i(clk_i), .rst_ni(rst_ni), .reg_we_i(reg_we_i), .reg_addr_i(reg_addr_i),
  .reg_wdata_i(reg_wdata_i), .reg_rdata_o(reg_rdata_o), .bus_dma_i(bus_dma_i),
  .bus_fetch_i(bus_fetch_i), .insn_done_i(insn_done_i), .brk_req_o(brk_req_o),
  .hit(hit), .pending(pending), .cnt(cnt), .cpu_f(cpu_f), .dma_f(dma_f),
  .cnt_en(cfg.cnt_en), .after(cfg.after)
);

// File: tb/sim_brk_channel.sv
module sim_brk_channel;
  localparam int CLK_PERIOD = 10;
  localparam int AW = 32, DW = 32, CW = 16;

  logic clk = 0, rst_n = 0;
  logic we = 0, v = 0, wr = 0, dm = 0, fe = 0, dn = 0;
  logic [1:0] ra = 0;
  logic [DW-1:0] wd = 0, rdata;
  logic [AW-1:0] ba = 0;
  logic req;

  always #(CLK_PERIOD/2) clk = ~clk;

  brk_channel #(.AW(AW), .DW(DW), .CW(CW)) u0 (
    .clk_i(clk), .rst_ni(rst_n), .reg_we_i(we), .reg_addr_i(ra),
    .reg_wdata_i(wd), .reg_rdata_o(rdata), .bus_valid_i(v), .bus_addr_i(ba),
    .bus_write_i(wr), .bus_dma_i(dm), .bus_fetch_i(fe), .insn_done_i(dn),
    .brk_req_o(req)
  );

  int n_chk = 0, n_fail = 0;
  bit finished = 0;

  // model state
  logic [AW-1:0] m_addr = 0, m_mask = 0;
  logic [5:0]    m_cfg = 0;
  logic          m_cpu = 0, m_dma = 0, m_pend = 0, m_req = 0;
  logic [CW-1:0] m_cnt = 0;

  task automatic check(input string tag, input logic [DW-1:0] act, input logic [DW-1:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  function automatic logic [DW-1:0] mread(input logic [1:0] a);
    case (a)
      2'd0: return DW'(m_addr);
      2'd1: return DW'(m_mask);
      2'd2: return DW'({m_dma, m_cpu, 2'b00, m_cfg});
      default: return DW'(m_cnt);
    endcase
  endfunction

  function automatic logic mhit();
    return v && (((ba ^ m_addr) & ~m_mask) == '0) &&
           ((m_cfg[0] && !dm) || (m_cfg[1] && dm)) &&
           ((m_cfg[2] && !wr) || (m_cfg[3] && wr));
  endfunction

  // inputs are already on the pins; called just after a falling edge
  task automatic step(input string tag);
    logic h, f, d;
    #1;
    check({tag, " rdata"}, rdata, mread(ra));
    h = mhit();
    f = m_cfg[5] ? (h && m_cnt == CW'(1)) : h;
    d = f && fe && m_cfg[4];
    m_req = (f && !d) || (m_pend && dn);
    m_pend = d ? 1'b1 : (dn ? 1'b0 : m_pend);
    if (we && ra == 2'd3) m_cnt = wd[CW-1:0];
    else if (m_cfg[5] && h && m_cnt != 0) m_cnt = m_cnt - 1'b1;
    m_cpu = (h && !dm) || (m_cpu && !(we && ra == 2'd2 && !wd[8]));
    m_dma = (h && dm)  || (m_dma && !(we && ra == 2'd2 && !wd[9]));
    if (we) case (ra)
      2'd0: m_addr = wd[AW-1:0];
      2'd1: m_mask = wd[AW-1:0];
      2'd2: m_cfg  = wd[5:0];
      default: ;
    endcase
    @(posedge clk); @(negedge clk);
    check({tag, " brk_req"}, DW'(req), DW'(m_req));
    we = 0; v = 0; dn = 0; fe = 0;
  endtask

  task automatic wreg(input logic [1:0] a, input logic [DW-1:0] d, input string tag);
    we = 1; ra = a; wd = d; step(tag);
  endtask

  task automatic bus(input logic [AW-1:0] a, input logic w, input logic m,
                     input logic f, input logic n, input string tag);
    v = 1; ba = a; wr = w; dm = m; fe = f; dn = n; step(tag);
  endtask

  task automatic rd(input logic [1:0] a, input string tag);
    ra = a; step(tag);
  endtask

  initial begin
    #(CLK_PERIOD * 200000);
    if (!finished) begin
      n_fail++;
      $display("FAIL watchdog actual=timeout expected=done");
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd4177));
    repeat (3) @(negedge clk);
    check("R1 brk_req in reset", DW'(req), '0);
    rst_n = 1;
    @(negedge clk);
    for (int i = 0; i < 4; i++) rd(2'(i), "R1");
    check("R1 ctrl literal", mread(2'd2), '0);

    // basic match, both masters, either direction
    wreg(2'd0, 32'h0000_1000, "R2");
    wreg(2'd2, 32'h0000_000F, "R3");
    ra = 2'd2;
    bus(32'h1000, 0, 0, 0, 0, "R7 cpu hit");
    check("R7 literal", DW'(req), 1);
    rd(2'd2, "R5 cpu flag");
    bus(32'h1004, 0, 0, 0, 0, "R2 miss");
    wreg(2'd1, 32'h0000_000F, "R2 mask");
    bus(32'h1004, 1, 0, 0, 0, "R2 masked hit");
    // master select cpu only
    wreg(2'd2, 32'h0000_010D, "R3 cpu only");
    bus(32'h1000, 0, 1, 0, 0, "R3 dma blocked");
    bus(32'h1000, 0, 0, 0, 0, "R3 cpu passes");
    // direction read only
    wreg(2'd2, 32'h0000_0107, "R4 read only");
    bus(32'h1000, 1, 0, 0, 0, "R4 write blocked");
    bus(32'h1000, 0, 0, 0, 0, "R4 read passes");
    // flag write semantics
    ra = 2'd2;
    wreg(2'd2, 32'h0000_010F, "R5 write 1 keeps");
    wreg(2'd2, 32'h0000_000F, "R5 write 0 clears");
    rd(2'd2, "R5 cleared");
    check("R5 literal", rdata & 32'h300, 0);
    bus(32'h1000, 0, 1, 0, 0, "R6 dma hit");
    rd(2'd2, "R6 dma flag");
    check("R6 literal", rdata & 32'h300, 32'h200);
    we = 1; ra = 2'd2; wd = 32'h0000_000F; v = 1; ba = 32'h1000; dm = 1; wr = 0;
    step("R6 set wins over clear");
    rd(2'd2, "R6 still set");
    // count
    wreg(2'd2, 32'h0000_002F, "R8 cnt en");
    wreg(2'd3, 32'd3, "R8 load");
    ra = 2'd3;
    bus(32'h1000, 0, 0, 0, 0, "R8 hit1");
    bus(32'h1000, 0, 0, 0, 0, "R8 hit2");
    bus(32'h1000, 0, 0, 0, 0, "R8 hit3 fires");
    check("R8 literal fire", DW'(req), 1);
    rd(2'd3, "R8 count zero");
    check("R8 literal cnt", rdata, 0);
    bus(32'h1000, 0, 0, 0, 0, "R8 no fire at 0");
    // write collides with hit
    wreg(2'd3, 32'd1, "R12 load 1");
    we = 1; ra = 2'd3; wd = 32'd5; v = 1; ba = 32'h1000; dm = 0;
    step("R12 collide");
    rd(2'd3, "R12 count 5");
    // fetch before execution
    wreg(2'd2, 32'h0000_000F, "R9 cfg");
    bus(32'h1000, 0, 0, 1, 0, "R9 fetch immediate");
    // fetch after execution
    wreg(2'd2, 32'h0000_001F, "R10 cfg");
    dn = 1; rd(2'd2, "R10 stray done ignored");
    bus(32'h1000, 0, 0, 1, 0, "R10 fetch deferred");
    rd(2'd2, "R10 waiting");
    rd(2'd2, "R10 waiting");
    dn = 1; rd(2'd2, "R10 done fires");
    bus(32'h1000, 0, 0, 0, 0, "R10 nonfetch immediate");
    // reserved bits
    wreg(2'd2, 32'hFFFF_FCFF, "R11 all ones");
    rd(2'd2, "R11 readback");
    check("R11 literal", rdata & 32'hFFFF_FCC0, 0);

    // constrained random
    for (int i = 0; i < 4000; i++) begin
      ra = 2'($urandom);
      if ($urandom_range(15) == 0) begin
        we = 1;
        case (ra)
          2'd0: wd = $urandom;
          2'd1: wd = $urandom & 32'h1F;
          2'd2: wd = $urandom;
          default: wd = $urandom_range(4);
        endcase
      end
      v  = ($urandom_range(3) != 0);
      ba = m_addr ^ ($urandom & 32'h1F);
      wr = 1'($urandom); dm = 1'($urandom); fe = 1'($urandom);
      dn = ($urandom_range(3) == 0);
      step("RAND");
    end

    finished = 1;
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
    $finish;
  end
endmodule